// File: doc/BRIEF.md
# Virtual CPU Interrupt Interface

This block is the guest-facing half of a virtual interrupt controller. A hypervisor loads interrupts into a small bank of list entries that belongs to each virtual CPU. A guest running on that virtual CPU then sees a compact register window on a 32-bit memory-mapped bus. The window has an enable, a priority threshold, an acknowledge register that claims the most urgent pending entry, and an end-of-interrupt register that retires an entry. Each virtual CPU has a level-sensitive virtual IRQ line. The block raises that line when work is waiting.

List entry layout, for every entry:

| Bits | Field |
|------|-------|
| 9:0 | virtual interrupt ID |
| 12:10 | source CPU |
| 19 | maintenance flag (stored only) |
| 27:23 | priority (lower value means more urgent) |
| 29:28 | state: 0 invalid, 1 pending, 2 active, 3 pending and active |
| 30 | group (stored only) |
| 31 | hardware link (stored only) |

The guest selects a register with `bus_addr[3:2]`:

| `bus_addr[3:2]` | Register |
|-----------------|----------|
| 0 | control, enable in bit 0 |
| 1 | priority threshold, in bits [4:0] |
| 2 | acknowledge |
| 3 | end-of-interrupt |

`bus_cpu` chooses which virtual CPU's bank the access reaches.

Top module: `vcpu_irq_iface`

## Requirements
- R1: A read of the acknowledge register returns 1023 when the accessed CPU's enable bit is 0, or when no entry qualifies under R3 and R5.
- R2: A successful acknowledge returns the ID in bits [9:0] and the source CPU in bits [12:10], with all higher bits 0. Any read result appears on `bus_rdata` in the cycle after the request. `bus_rdata` holds its value while no read is made.
- R3: An entry is pending when its state is 1 or 3. Acknowledge chooses the pending entry with the smallest priority value. On a tie, the lowest entry index wins.
- R4: A successful acknowledge sets the chosen entry's state to 2 (active), so a later acknowledge does not return it again.
- R5: Only entries whose priority is strictly below the 5-bit threshold can be acknowledged. The threshold is written and read back through bits [4:0] of register 1.
- R6: An end-of-interrupt write takes the ID from bits [9:0] and the source CPU from bits [12:10]. It sets to invalid the lowest-index non-invalid entry whose ID and source CPU both match.
- R7: An end-of-interrupt write that matches no entry changes nothing. End-of-interrupt works whether or not the enable bit is set.
- R8: `virq[c]` is registered and changes one clock after the state that causes it. When the line is low, it rises if any entry is pending and the enable bit is 1. When the line is high, it stays high until no entry is pending, even if the enable bit is cleared.
- R9: A hypervisor write stores `hv_wdata` into entry `hv_addr[HV_AW-1:2]` of CPU `hv_cpu`. If a guest acknowledge or end-of-interrupt touches the same entry in the same cycle, the hypervisor write wins. The acknowledge still returns the value chosen from the state before the write.
- R10: After reset, all entries are invalid, every enable bit is 0, every threshold is 31, `virq` is 0 and `bus_rdata` is 0.
- R11: Each CPU has its own entries, enable bit and threshold. An access with `bus_cpu` = c affects and reports only CPU c.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | clock |
| rst_n | input | 1 | synchronous active-low reset |
| hv_wr_en | input | 1 | hypervisor entry write strobe |
| hv_cpu | input | CPU_W | target virtual CPU of the hypervisor write |
| hv_addr | input | HV_AW | byte offset of the entry; bits [HV_AW-1:2] give the index |
| hv_wdata | input | 32 | entry value to store |
| bus_req | input | 1 | guest access strobe, one cycle per access |
| bus_we | input | 1 | 1 write, 0 read |
| bus_cpu | input | CPU_W | virtual CPU making the access |
| bus_addr | input | 4 | byte offset of the register |
| bus_wdata | input | 32 | guest write data |
| bus_rdata | output | 32 | read data, registered |
| virq | output | NUM_CPU | virtual IRQ line for each CPU |

## Verification
A hypervisor entry write can land in the same cycle as a guest acknowledge or end-of-interrupt that targets the same entry. The bench creates this collision by driving both ports in one cycle. It then checks two things: the acknowledge data still reflects the old entry, and a second acknowledge returns the newly written entry, which shows the hypervisor write won the collision. The enable-clear-while-pending case is also judged on the virq line, which must stay high until an end-of-interrupt drains the bank.

// File: rtl/vcpu_irq_pkg.sv
`timescale 1ns/1ps
// Shared types and constants for the virtual CPU interrupt interface.
// Assumes a 32-bit entry word, 10-bit IDs, 3-bit source CPU and a 5-bit priority.
package vcpu_irq_pkg;
    localparam int ID_W   = 10;
    localparam int SRC_W  = 3;
    localparam int PRIO_W = 5;

    localparam logic [31:0] NO_IRQ = 32'd1023;

    localparam logic [1:0] REG_CTL = 2'd0;
    localparam logic [1:0] REG_PMR = 2'd1;
    localparam logic [1:0] REG_ACK = 2'd2;
    localparam logic [1:0] REG_EOI = 2'd3;

    typedef enum logic [1:0] {
        ST_INV  = 2'd0,
        ST_PEND = 2'd1,
        ST_ACT  = 2'd2,
        ST_PACT = 2'd3
    } lr_state_e;

    typedef struct packed {
        logic              hw;
        logic              grp;
        lr_state_e         state;
        logic [PRIO_W-1:0] prio;
        logic [2:0]        rsv_hi;
        logic              eoi_mnt;
        logic [5:0]        rsv_lo;
        logic [SRC_W-1:0]  src;
        logic [ID_W-1:0]   vid;
    } lr_t;
endpackage

// File: rtl/vcpu_lr_bank.sv
`timescale 1ns/1ps
// Holds the list entries of one virtual CPU and applies the updates to them.
// Assumes at most one guest update (acknowledge or EOI) per cycle.
// Update priority: a hypervisor write beats an acknowledge, which beats an EOI.
module vcpu_lr_bank
    import vcpu_irq_pkg::*;
#(
    parameter int  NUM_LR = 4,
    localparam int IDX_W  = (NUM_LR > 1) ? $clog2(NUM_LR) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    hv_we,
    input  logic [IDX_W-1:0]        hv_idx,
    input  lr_t                     hv_data,
    input  logic                    ack_we,
    input  logic [IDX_W-1:0]        ack_idx,
    input  logic                    eoi_we,
    input  logic [IDX_W-1:0]        eoi_idx,
    output lr_t  [NUM_LR-1:0]       lrs,
    output logic                    pend_any
);
    for (genvar i = 0; i < NUM_LR; i++) begin : g_ent
        // Purpose: per-entry storage with the update priority described above.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                lrs[i] <= '0;
            end else if (hv_we && hv_idx == IDX_W'(i)) begin
                lrs[i] <= hv_data;
            end else if (ack_we && ack_idx == IDX_W'(i)) begin
                lrs[i].state <= ST_ACT;
            end else if (eoi_we && eoi_idx == IDX_W'(i)) begin
                lrs[i].state <= ST_INV;
            end
        end
    end

    // Purpose: flag whether any entry currently holds a pending interrupt.
    always_comb begin
        pend_any = 1'b0;
        for (int i = 0; i < NUM_LR; i++) begin
            pend_any = pend_any | lrs[i].state[0];
        end
    end
endmodule

// File: rtl/vcpu_ack_pick.sv
`timescale 1ns/1ps
// Chooses the entry that an acknowledge would claim: pending, priority
// strictly below the threshold, smallest priority value, lowest index on ties.
// Purely combinational.
module vcpu_ack_pick
    import vcpu_irq_pkg::*;
#(
    parameter int  NUM_LR = 4,
    localparam int IDX_W  = (NUM_LR > 1) ? $clog2(NUM_LR) : 1
) (
    input  lr_t  [NUM_LR-1:0] lrs,
    input  logic [PRIO_W-1:0] mask,
    output logic              found,
    output logic [IDX_W-1:0]  idx
);
    logic [PRIO_W-1:0] best;

    // Purpose: linear scan keeping the strictly better candidate.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        best  = '1;
        for (int i = 0; i < NUM_LR; i++) begin
            if (lrs[i].state[0] && (lrs[i].prio < mask) &&
                (!found || lrs[i].prio < best)) begin
                found = 1'b1;
                idx   = IDX_W'(i);
                best  = lrs[i].prio;
            end
        end
    end
endmodule

// File: rtl/vcpu_eoi_find.sv
`timescale 1ns/1ps
// Finds the lowest-index non-invalid entry whose ID and source CPU both
// match an end-of-interrupt word. Purely combinational.
module vcpu_eoi_find
    import vcpu_irq_pkg::*;
#(
    parameter int  NUM_LR = 4,
    localparam int IDX_W  = (NUM_LR > 1) ? $clog2(NUM_LR) : 1
) (
    input  lr_t  [NUM_LR-1:0] lrs,
    input  logic [ID_W-1:0]   vid,
    input  logic [SRC_W-1:0]  src,
    output logic              found,
    output logic [IDX_W-1:0]  idx
);
    // Purpose: first-match search from index 0 upward.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = 0; i < NUM_LR; i++) begin
            if (!found && lrs[i].state != ST_INV &&
                lrs[i].vid == vid && lrs[i].src == src) begin
                found = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/vcpu_irq_iface.sv
`timescale 1ns/1ps
// Guest-facing virtual interrupt interface. A hypervisor port loads the
// list entries of each virtual CPU. A 32-bit register bus offers enable,
// priority threshold, acknowledge and end-of-interrupt. Each CPU has a
// registered virtual IRQ line.
// Assumes one guest access per cycle; read data is registered.
module vcpu_irq_iface
    import vcpu_irq_pkg::*;
#(
    parameter int  NUM_CPU = 2,
    parameter int  NUM_LR  = 4,
    localparam int CPU_W   = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1,
    localparam int IDX_W   = (NUM_LR > 1) ? $clog2(NUM_LR) : 1,
    localparam int HV_AW   = IDX_W + 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               hv_wr_en,
    input  logic [CPU_W-1:0]   hv_cpu,
    input  logic [HV_AW-1:0]   hv_addr,
    input  logic [31:0]        hv_wdata,
    input  logic               bus_req,
    input  logic               bus_we,
    input  logic [CPU_W-1:0]   bus_cpu,
    input  logic [3:0]         bus_addr,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    output logic [NUM_CPU-1:0] virq
);
    lr_t  [NUM_LR-1:0] lrs_all [NUM_CPU];
    logic [NUM_CPU-1:0] pend_any;
    logic [NUM_CPU-1:0] en_q;
    logic [PRIO_W-1:0]  mask_q [NUM_CPU];
    logic [NUM_CPU-1:0] virq_q;
    logic [31:0]        rdata_q;

    lr_t  [NUM_LR-1:0]  sel_lrs;
    logic [1:0]         reg_sel;
    logic               rd_go, wr_go;
    logic               pick_found, find_found;
    logic [IDX_W-1:0]   pick_idx, find_idx;
    logic               ack_fire, eoi_fire;
    logic [31:0]        rd_val;
    logic [IDX_W-1:0]   hv_idx;

    assign sel_lrs = lrs_all[bus_cpu];
    assign reg_sel = bus_addr[3:2];
    assign rd_go   = bus_req & ~bus_we;
    assign wr_go   = bus_req & bus_we;
    assign hv_idx  = hv_addr[HV_AW-1:2];

    vcpu_ack_pick #(.NUM_LR(NUM_LR)) u_pick (
        .lrs   (sel_lrs),
        .mask  (mask_q[bus_cpu]),
        .found (pick_found),
        .idx   (pick_idx)
    );

    vcpu_eoi_find #(.NUM_LR(NUM_LR)) u_find (
        .lrs   (sel_lrs),
        .vid   (bus_wdata[ID_W-1:0]),
        .src   (bus_wdata[ID_W+SRC_W-1:ID_W]),
        .found (find_found),
        .idx   (find_idx)
    );

    assign ack_fire = rd_go && reg_sel == REG_ACK && pick_found && en_q[bus_cpu];
    assign eoi_fire = wr_go && reg_sel == REG_EOI && find_found;

    for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
        vcpu_lr_bank #(.NUM_LR(NUM_LR)) u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .hv_we    (hv_wr_en && hv_cpu == CPU_W'(c)),
            .hv_idx   (hv_idx),
            .hv_data  (lr_t'(hv_wdata)),
            .ack_we   (ack_fire && bus_cpu == CPU_W'(c)),
            .ack_idx  (pick_idx),
            .eoi_we   (eoi_fire && bus_cpu == CPU_W'(c)),
            .eoi_idx  (find_idx),
            .lrs      (lrs_all[c]),
            .pend_any (pend_any[c])
        );

        // Purpose: per-CPU enable and priority threshold registers.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                en_q[c]   <= 1'b0;
                mask_q[c] <= '1;
            end else if (wr_go && bus_cpu == CPU_W'(c)) begin
                if (reg_sel == REG_CTL) en_q[c]   <= bus_wdata[0];
                if (reg_sel == REG_PMR) mask_q[c] <= bus_wdata[PRIO_W-1:0];
            end
        end

        // Purpose: virtual IRQ line; rises only when enabled, falls only when drained.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                virq_q[c] <= 1'b0;
            end else if (virq_q[c]) begin
                virq_q[c] <= pend_any[c];
            end else begin
                virq_q[c] <= pend_any[c] & en_q[c];
            end
        end
    end

    // Purpose: read data mux for the addressed register of the accessing CPU.
    always_comb begin
        rd_val = '0;
        case (reg_sel)
            REG_CTL: rd_val = {31'd0, en_q[bus_cpu]};
            REG_PMR: rd_val = {{(32-PRIO_W){1'b0}}, mask_q[bus_cpu]};
            REG_ACK: rd_val = (pick_found && en_q[bus_cpu])
                              ? {19'd0, sel_lrs[pick_idx].src, sel_lrs[pick_idx].vid}
                              : NO_IRQ;
            default: rd_val = '0;
        endcase
    end

    // Purpose: register read data; hold it between reads.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (rd_go) begin
            rdata_q <= rd_val;
        end
    end

    assign bus_rdata = rdata_q;
    assign virq      = virq_q;
endmodule

// File: rtl/vcpu_irq_iface_chk.sv
`timescale 1ns/1ps
// Assertion checker for vcpu_irq_iface, bound to every instance.
// Observes the bus, the IRQ lines and the per-CPU enable and pending flags.
module vcpu_irq_iface_chk #(
    parameter int NUM_CPU = 2,
    parameter int CPU_W   = 1
) (
    input logic               clk,
    input logic               rst_n,
    input logic               bus_req,
    input logic               bus_we,
    input logic [CPU_W-1:0]   bus_cpu,
    input logic [3:0]         bus_addr,
    input logic [31:0]        bus_rdata,
    input logic [NUM_CPU-1:0] virq,
    input logic [NUM_CPU-1:0] en_q,
    input logic [NUM_CPU-1:0] pend_any
);
    // R1: acknowledge with the enable clear reads the empty code
    p_ack_disabled_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_we && bus_addr[3:2] == 2'd2 && !en_q[bus_cpu])
        |=> (bus_rdata == 32'd1023));

    // R2: read data holds while no read is made
    p_rdata_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_req && !bus_we) |=> $stable(bus_rdata));

    for (genvar c = 0; c < NUM_CPU; c++) begin : g_c
        // R8: the line rises only after pending work with the enable set
        p_virq_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(virq[c]) |-> $past(pend_any[c] && en_q[c]));

        // R8: the line falls only after the bank has drained
        p_virq_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(virq[c]) |-> $past(!pend_any[c]));

        // R8: while pending work remains, a raised line stays raised
        p_virq_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (virq[c] && pend_any[c]) |=> virq[c]);
    end
endmodule

bind vcpu_irq_iface vcpu_irq_iface_chk #(.NUM_CPU(NUM_CPU), .CPU_W(CPU_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_req   (bus_req),
    .bus_we    (bus_we),
    .bus_cpu   (bus_cpu),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata),
    .virq      (virq),
    .en_q      (en_q),
    .pend_any  (pend_any)
);

// File: tb/vcpu_irq_iface_tb.sv
`timescale 1ns/1ps
// Self-checking bench: a vector table walked by one loop, then directed
// tests for reset, same-cycle collisions and mid-run reset.
module vcpu_irq_iface_tb;
    localparam int NCPU = 2;
    localparam logic [1:0] OP_HV = 2'd0, OP_WR = 2'd1, OP_RD = 2'd2;
    localparam logic [3:0] A_CTL = 4'h0, A_PMR = 4'h4, A_ACK = 4'h8, A_EOI = 4'hC;

    typedef struct packed {
        logic [1:0]  op;
        logic        cpu;
        logic [3:0]  addr;
        logic [31:0] data;
        logic        chk;
        logic [31:0] exp_rd;
        logic [1:0]  exp_virq;
    } vec_t;

    // Entry word: state[29:28] prio[27:23] src[12:10] id[9:0]
    function automatic logic [31:0] lrw(input logic [1:0] st, input logic [4:0] pr,
                                        input logic [2:0] sc, input logic [9:0] id);
        return {2'b00, st, pr, 3'b000, 1'b0, 6'd0, sc, id};
    endfunction

    function automatic vec_t mk(input logic [1:0] op, input logic cpu, input logic [3:0] a,
                                input logic [31:0] d, input logic chk, input logic [31:0] er,
                                input logic [1:0] ev);
        return '{op: op, cpu: cpu, addr: a, data: d, chk: chk, exp_rd: er, exp_virq: ev};
    endfunction

    localparam int NV = 32;
    localparam vec_t VECS [NV] = '{
        mk(OP_RD, 1'b0, A_ACK, 32'd0, 1'b1, 32'd1023, 2'b00),              // R1 empty
        mk(OP_HV, 1'b0, 4'h0, lrw(2'd1, 5'd10, 3'd2, 10'd33), 1'b0, 0, 2'b00), // R8 enable clear
        mk(OP_RD, 1'b0, A_ACK, 32'd0, 1'b1, 32'd1023, 2'b00),              // R1 disabled
        mk(OP_WR, 1'b0, A_CTL, 32'd1, 1'b0, 0, 2'b01),                     // R8 rise
        mk(OP_RD, 1'b0, A_CTL, 32'd0, 1'b1, 32'd1, 2'b01),                 // R11 ctl read
        mk(OP_HV, 1'b0, 4'h4, lrw(2'd1, 5'd4, 3'd1, 10'd40), 1'b0, 0, 2'b01),  // R9
        mk(OP_HV, 1'b0, 4'h8, lrw(2'd1, 5'd4, 3'd0, 10'd41), 1'b0, 0, 2'b01),  // R9
        mk(OP_RD, 1'b0, A_ACK, 32'd0, 1'b1, 32'd1064, 2'b01),              // R2 R3 tie lowest idx
        mk(OP_RD, 1'b0, A_ACK, 32'd0, 1'b1, 32'd41, 2'b01),                // R3 R4
        mk(OP_RD, 1'b0, A_ACK, 32'd0, 1'b1, 32'd2081, 2'b00),              // R2 R8 fall
        mk(OP_RD, 1'b0, A_ACK, 32'd0, 1'b1, 32'd1023, 2'b00),              // R4 all active
        mk(OP_HV, 1'b0, 4'hC, lrw(2'd1, 5'd20, 3'd3, 10'd7), 1'b0, 0, 2'b01),
        mk(OP_WR, 1'b0, A_EOI, 32'd2055, 1'b0, 0, 2'b01),                  // R7 wrong cpu
        mk(OP_WR, 1'b0, A_EOI, 32'd3080, 1'b0, 0, 2'b01),                  // R7 wrong id
        mk(OP_WR, 1'b0, A_EOI, 32'd3079, 1'b0, 0, 2'b00),                  // R6 match
        mk(OP_RD, 1'b0, A_ACK, 32'd0, 1'b1, 32'd1023, 2'b00),              // R6 retired
        mk(OP_WR, 1'b0, A_PMR, 32'd5, 1'b0, 0, 2'b00),                     // R5
        mk(OP_HV, 1'b0, 4'hC, lrw(2'd1, 5'd5, 3'd0, 10'd12), 1'b0, 0, 2'b01),
        mk(OP_RD, 1'b0, A_ACK, 32'd0, 1'b1, 32'd1023, 2'b01),              // R5 equal to mask
        mk(OP_HV, 1'b0, 4'h8, lrw(2'd1, 5'd4, 3'd0, 10'd13), 1'b0, 0, 2'b01),
        mk(OP_RD, 1'b0, A_ACK, 32'd0, 1'b1, 32'd13, 2'b01),                // R5 below mask
        mk(OP_RD, 1'b0, A_PMR, 32'd0, 1'b1, 32'd5, 2'b01),                 // R5 read back
        mk(OP_WR, 1'b0, A_CTL, 32'd0, 1'b0, 0, 2'b01),                     // R8 stays high
        mk(OP_RD, 1'b0, A_ACK, 32'd0, 1'b1, 32'd1023, 2'b01),              // R1 disabled
        mk(OP_WR, 1'b0, A_EOI, 32'd12, 1'b0, 0, 2'b00),                    // R7 EOI while disabled
        mk(OP_HV, 1'b0, 4'h0, lrw(2'd1, 5'd1, 3'd0, 10'd3), 1'b0, 0, 2'b00),   // R8 no rise
        mk(OP_WR, 1'b1, A_CTL, 32'd1, 1'b0, 0, 2'b00),                     // R11
        mk(OP_HV, 1'b1, 4'h0, lrw(2'd1, 5'd0, 3'd0, 10'd5), 1'b0, 0, 2'b10),   // R11
        mk(OP_RD, 1'b1, A_ACK, 32'd0, 1'b1, 32'd5, 2'b00),                 // R11
        mk(OP_RD, 1'b0, A_ACK, 32'd0, 1'b1, 32'd1023, 2'b00),              // R11 cpu0 unaffected
        mk(OP_HV, 1'b1, 4'h4, lrw(2'd3, 5'd2, 3'd1, 10'd6), 1'b0, 0, 2'b10),   // R3 state 3
        mk(OP_RD, 1'b1, A_ACK, 32'd0, 1'b1, 32'd1030, 2'b00)               // R3 R4
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hv_wr_en = 1'b0;
    logic [0:0]  hv_cpu = '0;
    logic [3:0]  hv_addr = '0;
    logic [31:0] hv_wdata = '0;
    logic        bus_req = 1'b0;
    logic        bus_we = 1'b0;
    logic [0:0]  bus_cpu = '0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [NCPU-1:0] virq;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    vcpu_irq_iface #(.NUM_CPU(NCPU), .NUM_LR(4)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .hv_wr_en(hv_wr_en), .hv_cpu(hv_cpu), .hv_addr(hv_addr), .hv_wdata(hv_wdata),
        .bus_req(bus_req), .bus_we(bus_we), .bus_cpu(bus_cpu), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .virq(virq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic drive_clear();
        hv_wr_en = 1'b0; bus_req = 1'b0; bus_we = 1'b0;
    endtask

    // One cycle carrying optional hypervisor and guest traffic, then one idle
    // cycle so the registered IRQ line reflects the update.
    task automatic cycle(input logic hv, input logic hc, input logic [3:0] ha, input logic [31:0] hd,
                         input logic br, input logic bw, input logic bc, input logic [3:0] ba,
                         input logic [31:0] bd);
        @(negedge clk);
        hv_wr_en = hv; hv_cpu = hc; hv_addr = ha; hv_wdata = hd;
        bus_req = br; bus_we = bw; bus_cpu = bc; bus_addr = ba; bus_wdata = bd;
        @(posedge clk);
        @(negedge clk);
        drive_clear();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic hv_put(input logic c, input logic [3:0] a, input logic [31:0] d);
        cycle(1'b1, c, a, d, 1'b0, 1'b0, 1'b0, 4'h0, 32'd0);
    endtask

    task automatic rd(input logic c, input logic [3:0] a);
        cycle(1'b0, 1'b0, 4'h0, 32'd0, 1'b1, 1'b0, c, a, 32'd0);
    endtask

    task automatic wr(input logic c, input logic [3:0] a, input logic [31:0] d);
        cycle(1'b0, 1'b0, 4'h0, 32'd0, 1'b1, 1'b1, c, a, d);
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R10: reset state at the ports
        check("R10 virq", {30'd0, virq}, 32'd0);
        check("R10 rdata", bus_rdata, 32'd0);
        rst_n = 1'b1;
        rd(1'b0, A_CTL); check("R10 ctl", bus_rdata, 32'd0);
        rd(1'b1, A_PMR); check("R10 pmr", bus_rdata, 32'd31);

        for (int i = 0; i < NV; i++) begin
            case (VECS[i].op)
                OP_HV: hv_put(VECS[i].cpu, VECS[i].addr, VECS[i].data);
                OP_WR: wr(VECS[i].cpu, VECS[i].addr, VECS[i].data);
                default: rd(VECS[i].cpu, VECS[i].addr);
            endcase
            if (VECS[i].chk) check($sformatf("vec%0d rdata", i), bus_rdata, VECS[i].exp_rd);
            check($sformatf("vec%0d virq", i), {30'd0, virq}, {30'd0, VECS[i].exp_virq});
        end

        // R9: acknowledge and hypervisor write on the same entry in one cycle
        hv_put(1'b1, 4'h8, lrw(2'd1, 5'd0, 3'd0, 10'd9));
        cycle(1'b1, 1'b1, 4'h8, lrw(2'd1, 5'd0, 3'd0, 10'd10), 1'b1, 1'b0, 1'b1, A_ACK, 32'd0);
        check("R9 ack sees old entry", bus_rdata, 32'd9);
        check("R9 virq held", {30'd0, virq}, 32'd2);
        rd(1'b1, A_ACK);
        check("R9 hv write won over ack", bus_rdata, 32'd10);
        // R9: EOI and hypervisor write on the same entry in one cycle
        cycle(1'b1, 1'b1, 4'h8, lrw(2'd1, 5'd0, 3'd0, 10'd11), 1'b1, 1'b1, 1'b1, A_EOI, 32'd10);
        rd(1'b1, A_ACK);
        check("R9 hv write won over eoi", bus_rdata, 32'd11);
        check("R8 drained", {30'd0, virq}, 32'd0);

        // R10: mid-run reset clears entries, enables, thresholds and outputs
        hv_put(1'b1, 4'h0, lrw(2'd1, 5'd0, 3'd0, 10'd20));
        check("R8 pending line", {30'd0, virq}, 32'd2);
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check("R10 virq after reset", {30'd0, virq}, 32'd0);
        check("R10 rdata after reset", bus_rdata, 32'd0);
        rst_n = 1'b1;
        wr(1'b1, A_CTL, 32'd1);
        rd(1'b1, A_ACK);
        check("R10 entries cleared", bus_rdata, 32'd1023);
        rd(1'b0, A_PMR);
        check("R10 threshold reset", bus_rdata, 32'd31);

        done = 1'b1;
        finish_run();
    end
endmodule